// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupts

A sixteen-line general-purpose I/O bank reached through a 16-bit register port split into two windows. The data window reads back the synchronised pin levels and changes the output value and the output-enable vectors only through atomic set and clear strobes, so software never needs a read-modify-write to move one line. The interrupt window configures each line on its own as a level or an edge trigger (single edge of a chosen sense, or both edges), and holds acknowledge, acknowledge-block, mask and pending registers.

Pin inputs pass through a two-flop synchroniser; a third flop holds the previous synchronised level for edge detection. Edge events stay latched until a write-one acknowledge clears them, while level-mode lines report the live qualified level. The pending view is the raw event vector with masked lines removed, and the single interrupt output is the OR of that view, active high and level-sensitive, for a parent controller. Pads are modelled as separate out, enable and in vectors. The register port is plain control: a write strobe with window, offset and data, and a read path that returns the addressed register combinationally.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, output values, output enables, acknowledge-block, edge select, both-edge select and polarity are all 0, the mask is all ones and irq is 0.
- R2: In the data window (bus_win=0), writing offset 0x2 sets the enable of every line whose data bit is 1, writing offset 0x6 clears it, bits written 0 leave lines alone, and reading offset 0x2 returns the enable vector (1 = output) that drives pin_oe.
- R3: In the data window, writing offset 0x8 sets the output value of every line whose data bit is 1, writing offset 0x4 clears it, other lines keep their value, reading offset 0x8 returns the value vector that drives pin_out, and pin_out changes only on a data-window write.
- R4: Reading data-window offset 0x0 returns the pin levels through a two-flop synchroniser: a pin change driven before rising edge k is visible after edge k+1.
- R5: A line whose edge-select bit (interrupt window, bus_win=1, offset 0x4) is 0 is in level mode: its raw event equals the synchronised level when its polarity bit (offset 0x8) is 1 and the inverted level when it is 0, and an acknowledge write has no effect on it.
- R6: A line with edge select 1 and both-edge bit (offset 0x6) 0 latches an event on a rising synchronised edge when polarity is 1 and on a falling edge when polarity is 0; a pin change driven before edge k is latched at edge k+2 and stays latched.
- R7: A line with edge select 1 and both-edge bit 1 latches an event on either edge, whatever its polarity.
- R8: Writing 1 to a bit of the acknowledge register (offset 0x0) clears that line's latched event unless the line's acknowledge-block bit (offset 0x2) is 1; an edge detected in the same cycle as the acknowledge is kept.
- R9: A mask bit (offset 0xA) of 1 hides the line from the pending register (offset 0xC, read only) and from irq without discarding its latched event; clearing the mask shows it again.
- R10: irq is 1 exactly when the pending register is non-zero.
- R11: Switching a line from edge to level mode discards its latched event, so returning it to edge mode starts with no event.
- R12: Writes to offsets not listed above change nothing, and reads of them, of data-window offsets 0x4 and 0x6 and of interrupt offset 0x0 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_win | input | 1 | Window select: 0 data, 1 interrupt |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| pin_in | input | 16 | Pad input levels, asynchronous |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables, 1 = drive |
| irq | output | 1 | Active-high level interrupt to the parent |

## Verification
The acknowledge write and the edge detector both update the same latch, and they can land on one clock edge. The bench drives a pin transition and times an acknowledge write so that it reaches the latch on the very edge that records the new event, then reads pending and expects the bit still set; the same collision also arises freely in the random phase, where a cycle-level bench model decides every outcome with the event taking priority over the clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 4;

  // data window offsets
  localparam logic [ADDR_W-1:0] DOFS_LEVEL   = 4'h0;
  localparam logic [ADDR_W-1:0] DOFS_OE_SET  = 4'h2;
  localparam logic [ADDR_W-1:0] DOFS_OUT_CLR = 4'h4;
  localparam logic [ADDR_W-1:0] DOFS_OE_CLR  = 4'h6;
  localparam logic [ADDR_W-1:0] DOFS_OUT_SET = 4'h8;

  // interrupt window offsets
  localparam logic [ADDR_W-1:0] IOFS_ACK     = 4'h0;
  localparam logic [ADDR_W-1:0] IOFS_ACK_BLK = 4'h2;
  localparam logic [ADDR_W-1:0] IOFS_EDGE    = 4'h4;
  localparam logic [ADDR_W-1:0] IOFS_BOTH    = 4'h6;
  localparam logic [ADDR_W-1:0] IOFS_POL     = 4'h8;
  localparam logic [ADDR_W-1:0] IOFS_MASK    = 4'hA;
  localparam logic [ADDR_W-1:0] IOFS_PEND    = 4'hC;

  typedef struct packed {
    logic oe_set;
    logic oe_clr;
    logic out_set;
    logic out_clr;
    logic ack;
    logic ack_blk;
    logic edge_sel;
    logic both;
    logic pol;
    logic mask;
  } wr_dec_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= d;
      lvl      <= meta_q;
      lvl_prev <= lvl;
    end
  end
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic lvl_prev,
  input  logic edge_mode,
  input  logic both_edges,
  input  logic pol,
  input  logic ack_clr,
  output logic raw,
  output logic held
);
  logic rise, fall, hit;

  always_comb begin
    rise = lvl & ~lvl_prev;
    fall = ~lvl & lvl_prev;
    if (both_edges)  hit = rise | fall;
    else if (pol)    hit = rise;
    else             hit = fall;
  end

  // a fresh edge outranks a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)          held <= 1'b0;
    else if (!edge_mode) held <= 1'b0;
    else                 held <= (held & ~ack_clr) | hit;
  end

  assign raw = edge_mode ? held : ~(lvl ^ pol);
endmodule

// File: rtl/gpio_data_regs.sv
module gpio_data_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_set,
  input  logic         oe_clr,
  input  logic         out_set,
  input  logic         out_clr,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] out_q,
  output logic [W-1:0] oe_q
);
  logic [W-1:0] oe_s, oe_c, out_s, out_c;

  assign oe_s  = oe_set  ? wbits : '0;
  assign oe_c  = oe_clr  ? wbits : '0;
  assign out_s = out_set ? wbits : '0;
  assign out_c = out_clr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= (out_q | out_s) & ~out_c;
      oe_q  <= (oe_q  | oe_s)  & ~oe_c;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic              irq
);
  localparam int unsigned W = NUM_LINES;

  wr_dec_t      dec;
  logic [W-1:0] wbits;
  logic [W-1:0] lvl, lvl_prev;
  logic [W-1:0] ack_blk_q, edge_q, both_q, pol_q, mask_q;
  logic [W-1:0] ack_clr, raw_evt, evt_latch, pend;

  assign wbits = bus_wdata[W-1:0];

  always_comb begin
    dec = '0;
    if (bus_wr && !bus_win) begin
      dec.oe_set  = (bus_addr == DOFS_OE_SET);
      dec.oe_clr  = (bus_addr == DOFS_OE_CLR);
      dec.out_set = (bus_addr == DOFS_OUT_SET);
      dec.out_clr = (bus_addr == DOFS_OUT_CLR);
    end
    if (bus_wr && bus_win) begin
      dec.ack      = (bus_addr == IOFS_ACK);
      dec.ack_blk  = (bus_addr == IOFS_ACK_BLK);
      dec.edge_sel = (bus_addr == IOFS_EDGE);
      dec.both     = (bus_addr == IOFS_BOTH);
      dec.pol      = (bus_addr == IOFS_POL);
      dec.mask     = (bus_addr == IOFS_MASK);
    end
  end

  gpio_in_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d        (pin_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  gpio_data_regs #(.W(W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .oe_set  (dec.oe_set),
    .oe_clr  (dec.oe_clr),
    .out_set (dec.out_set),
    .out_clr (dec.out_clr),
    .wbits   (wbits),
    .out_q   (pin_out),
    .oe_q    (pin_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_blk_q <= '0;
      edge_q    <= '0;
      both_q    <= '0;
      pol_q     <= '0;
      mask_q    <= '1;
    end else begin
      if (dec.ack_blk)  ack_blk_q <= wbits;
      if (dec.edge_sel) edge_q    <= wbits;
      if (dec.both)     both_q    <= wbits;
      if (dec.pol)      pol_q     <= wbits;
      if (dec.mask)     mask_q    <= wbits;
    end
  end

  assign ack_clr = dec.ack ? (wbits & ~ack_blk_q) : '0;

  for (genvar i = 0; i < W; i++) begin : g_line
    gpio_trig_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl        (lvl[i]),
      .lvl_prev   (lvl_prev[i]),
      .edge_mode  (edge_q[i]),
      .both_edges (both_q[i]),
      .pol        (pol_q[i]),
      .ack_clr    (ack_clr[i]),
      .raw        (raw_evt[i]),
      .held       (evt_latch[i])
    );
  end

  assign pend = raw_evt & ~mask_q;
  assign irq  = |pend;

  always_comb begin
    bus_rdata = '0;
    if (!bus_win) begin
      case (bus_addr)
        DOFS_LEVEL:   bus_rdata[W-1:0] = lvl;
        DOFS_OE_SET:  bus_rdata[W-1:0] = pin_oe;
        DOFS_OUT_SET: bus_rdata[W-1:0] = pin_out;
        default:      bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        IOFS_ACK_BLK: bus_rdata[W-1:0] = ack_blk_q;
        IOFS_EDGE:    bus_rdata[W-1:0] = edge_q;
        IOFS_BOTH:    bus_rdata[W-1:0] = both_q;
        IOFS_POL:     bus_rdata[W-1:0] = pol_q;
        IOFS_MASK:    bus_rdata[W-1:0] = mask_q;
        IOFS_PEND:    bus_rdata[W-1:0] = pend;
        default:      bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_win,
  input logic [3:0]           bus_addr,
  input logic [15:0]          bus_wdata,
  input logic [15:0]          bus_rdata,
  input logic [NUM_LINES-1:0] pin_in,
  input logic [NUM_LINES-1:0] pin_out,
  input logic [NUM_LINES-1:0] pin_oe,
  input logic                 irq,
  input logic [NUM_LINES-1:0] evt_latch,
  input logic [NUM_LINES-1:0] edge_q,
  input logic [NUM_LINES-1:0] mask_q
);
  localparam int unsigned W = NUM_LINES;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n)              age <= '0;
    else if (age != 2'd3)    age <= age + 2'd1;
  end

  p_oe_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_win && bus_addr == 4'h2)
    |=> ((pin_oe & $past(bus_wdata[W-1:0])) == $past(bus_wdata[W-1:0])));

  p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_win && bus_addr == 4'h4)
    |=> ((pin_out & $past(bus_wdata[W-1:0])) == '0));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_win) |=> $stable(pin_out));

  p_sync_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !bus_win && bus_addr == 4'h0)
    |-> (bus_rdata[W-1:0] == $past(pin_in, 2)));

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_win && bus_addr == 4'h0)
    |=> ((evt_latch & $past(evt_latch & edge_q)) == $past(evt_latch & edge_q)));

  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);

  p_level_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_latch & ~$past(edge_q)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_win   (bus_win),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .evt_latch (evt_latch),
  .edge_q    (edge_q),
  .mask_q    (mask_q)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_win = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [15:0] m_s1, m_s2, m_prev, m_latch, m_out, m_oe;
  logic [15:0] m_ackb, m_edge, m_both, m_pol, m_mask;
  logic [15:0] cur_pins = '0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NUM_LINES(16)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] f_raw();
    return (m_edge & m_latch) | (~m_edge & ~(m_pol ^ m_s2));
  endfunction

  function automatic logic [15:0] f_pend();
    return f_raw() & ~m_mask;
  endfunction

  function automatic logic [15:0] f_read(input logic win, input logic [3:0] a);
    if (!win) begin
      case (a)
        4'h0: return m_s2;
        4'h2: return m_oe;
        4'h8: return m_out;
        default: return 16'h0;
      endcase
    end
    case (a)
      4'h2: return m_ackb;
      4'h4: return m_edge;
      4'h6: return m_both;
      4'h8: return m_pol;
      4'hA: return m_mask;
      4'hC: return f_pend();
      default: return 16'h0;
    endcase
  endfunction

  function automatic string f_tag(input logic win, input logic [3:0] a);
    if (!win) begin
      case (a)
        4'h0: return "R4 level read";
        4'h2: return "R2 enable read";
        4'h8: return "R3 value read";
        default: return "R12 unlisted read";
      endcase
    end
    case (a)
      4'h2: return "R8 ack-block read";
      4'h4: return "R6 edge-select read";
      4'h6: return "R7 both-edge read";
      4'h8: return "R5 polarity read";
      4'hA: return "R9 mask read";
      4'hC: return "R9 pending read";
      default: return "R12 unlisted read";
    endcase
  endfunction

  // one clock: drive at the falling edge, compare the read before the rising
  // edge, advance the model at the rising edge, then compare the outputs
  task automatic step(input logic wr, input logic win, input logic [3:0] a,
                      input logic [15:0] wd, input logic [15:0] pins,
                      output logic [15:0] rd);
    logic [15:0] ev, clr, n_latch;
    @(negedge clk);
    bus_wr = wr; bus_win = win; bus_addr = a; bus_wdata = wd;
    pin_in = pins; cur_pins = pins;
    #5;
    rd = bus_rdata;
    chk(f_tag(win, a), bus_rdata, f_read(win, a));
    ev  = m_edge & ((m_both & (m_s2 ^ m_prev)) |
                    (~m_both & m_pol & m_s2 & ~m_prev) |
                    (~m_both & ~m_pol & ~m_s2 & m_prev));
    clr = (wr && win && a == 4'h0) ? (wd & ~m_ackb) : 16'h0;
    n_latch = m_edge & ((m_latch & ~clr) | ev);
    @(posedge clk);
    #1;
    m_latch = n_latch;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    if (wr && !win) begin
      if (a == 4'h2) m_oe  = m_oe | wd;
      if (a == 4'h6) m_oe  = m_oe & ~wd;
      if (a == 4'h8) m_out = m_out | wd;
      if (a == 4'h4) m_out = m_out & ~wd;
    end
    if (wr && win) begin
      if (a == 4'h2) m_ackb = wd;
      if (a == 4'h4) m_edge = wd;
      if (a == 4'h6) m_both = wd;
      if (a == 4'h8) m_pol  = wd;
      if (a == 4'hA) m_mask = wd;
    end
    chk("R3 pin_out", pin_out, m_out);
    chk("R2 pin_oe", pin_oe, m_oe);
    chk("R10 irq", {15'h0, irq}, {15'h0, |f_pend()});
  endtask

  task automatic wr_reg(input logic win, input logic [3:0] a, input logic [15:0] wd);
    logic [15:0] rd;
    step(1'b1, win, a, wd, cur_pins, rd);
  endtask

  task automatic rd_reg(input logic win, input logic [3:0] a, input logic [15:0] pins,
                        output logic [15:0] rd);
    step(1'b0, win, a, 16'h0, pins, rd);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    void'($urandom(32'h5EED_0017));
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_latch = 0; m_out = 0; m_oe = 0;
    m_ackb = 0; m_edge = 0; m_both = 0; m_pol = 0; m_mask = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 pin_out reset", pin_out, 16'h0);
    chk("R1 pin_oe reset", pin_oe, 16'h0);
    chk("R1 irq reset", {15'h0, irq}, 16'h0);
    rd_reg(1'b1, 4'hA, 16'h0, rd); chk("R1 mask reset", rd, 16'hFFFF);
    rd_reg(1'b1, 4'h8, 16'h0, rd); chk("R1 polarity reset", rd, 16'h0);

    // R2 / R3 set and clear strobes
    wr_reg(1'b0, 4'h2, 16'h00F0);
    wr_reg(1'b0, 4'h8, 16'h0A0A);
    wr_reg(1'b0, 4'h4, 16'h0002);
    rd_reg(1'b0, 4'h8, 16'h0, rd); chk("R3 value after set/clear", rd, 16'h0A08);
    wr_reg(1'b0, 4'h6, 16'h0010);
    rd_reg(1'b0, 4'h2, 16'h0, rd); chk("R2 enable after set/clear", rd, 16'h00E0);

    // R4 synchroniser depth
    rd_reg(1'b0, 4'h0, 16'h1234, rd);
    rd_reg(1'b0, 4'h0, 16'h1234, rd); chk("R4 level after one edge", rd, 16'h0000);
    rd_reg(1'b0, 4'h0, 16'h1234, rd); chk("R4 level after two edges", rd, 16'h1234);

    // R5 level mode on line 0
    wr_reg(1'b1, 4'hA, 16'hFFFE);
    wr_reg(1'b1, 4'h8, 16'h0001);
    rd_reg(1'b1, 4'hC, 16'h1235, rd);
    rd_reg(1'b1, 4'hC, 16'h1235, rd);
    rd_reg(1'b1, 4'hC, 16'h1235, rd); chk("R5 high level pending", rd, 16'h0001);
    wr_reg(1'b1, 4'h0, 16'h0001);
    rd_reg(1'b1, 4'hC, 16'h1235, rd); chk("R5 ack ignored in level mode", rd, 16'h0001);
    chk("R10 irq with pending", {15'h0, irq}, 16'h0001);
    wr_reg(1'b1, 4'h8, 16'h0000);
    rd_reg(1'b1, 4'hC, 16'h1235, rd); chk("R5 low sense on high pin", rd, 16'h0000);

    // R6 rising edge on line 1
    wr_reg(1'b1, 4'h4, 16'h0002);
    wr_reg(1'b1, 4'h8, 16'h0002);
    wr_reg(1'b1, 4'hA, 16'hFFFC);
    rd_reg(1'b1, 4'hC, 16'h1237, rd);
    rd_reg(1'b1, 4'hC, 16'h1237, rd);
    rd_reg(1'b1, 4'hC, 16'h1237, rd); chk("R6 not yet latched", rd, 16'h0000);
    rd_reg(1'b1, 4'hC, 16'h1237, rd); chk("R6 rising latched", rd, 16'h0002);
    for (int k = 0; k < 4; k++) rd_reg(1'b1, 4'hC, 16'h1235, rd);
    chk("R6 latch held through fall", rd, 16'h0002);

    // R8 acknowledge and acknowledge-block
    wr_reg(1'b1, 4'h0, 16'h0002);
    rd_reg(1'b1, 4'hC, 16'h1235, rd); chk("R8 ack clears", rd, 16'h0000);
    wr_reg(1'b1, 4'h2, 16'h0002);
    for (int k = 0; k < 4; k++) rd_reg(1'b1, 4'hC, 16'h1237, rd);
    chk("R8 second rise latched", rd, 16'h0002);
    wr_reg(1'b1, 4'h0, 16'h0002);
    rd_reg(1'b1, 4'hC, 16'h1237, rd); chk("R8 blocked ack", rd, 16'h0002);
    wr_reg(1'b1, 4'h2, 16'h0000);
    wr_reg(1'b1, 4'h0, 16'h0002);
    rd_reg(1'b1, 4'hC, 16'h1237, rd); chk("R8 ack after unblock", rd, 16'h0000);
    for (int k = 0; k < 3; k++) rd_reg(1'b1, 4'hC, 16'h1235, rd);
    chk("R6 falling ignored for rising sense", rd, 16'h0000);
    rd_reg(1'b1, 4'hC, 16'h1237, rd);
    rd_reg(1'b1, 4'hC, 16'h1237, rd);
    step(1'b1, 1'b1, 4'h0, 16'h0002, 16'h1237, rd);
    rd_reg(1'b1, 4'hC, 16'h1237, rd); chk("R8 same-cycle event wins", rd, 16'h0002);
    wr_reg(1'b1, 4'h0, 16'h0002);

    // R7 both edges
    wr_reg(1'b1, 4'h6, 16'h0002);
    for (int k = 0; k < 4; k++) rd_reg(1'b1, 4'hC, 16'h1235, rd);
    chk("R7 falling with both-edge", rd, 16'h0002);
    wr_reg(1'b1, 4'h0, 16'h0002);
    rd_reg(1'b1, 4'hC, 16'h1235, rd); chk("R8 ack both-edge", rd, 16'h0000);
    for (int k = 0; k < 4; k++) rd_reg(1'b1, 4'hC, 16'h1237, rd);
    chk("R7 rising with both-edge", rd, 16'h0002);

    // R9 mask keeps the latch
    wr_reg(1'b1, 4'hA, 16'hFFFF);
    chk("R9 irq masked", {15'h0, irq}, 16'h0000);
    rd_reg(1'b1, 4'hC, 16'h1237, rd); chk("R9 pending masked", rd, 16'h0000);
    wr_reg(1'b1, 4'hA, 16'hFFFC);
    chk("R10 irq after unmask", {15'h0, irq}, 16'h0001);
    rd_reg(1'b1, 4'hC, 16'h1237, rd); chk("R9 latch kept under mask", rd, 16'h0002);

    // R11 leaving edge mode discards the latch
    wr_reg(1'b1, 4'h8, 16'h0000);
    wr_reg(1'b1, 4'h4, 16'h0000);
    wr_reg(1'b1, 4'h4, 16'h0002);
    rd_reg(1'b1, 4'hC, 16'h1237, rd); chk("R11 latch discarded", rd, 16'h0000);

    // R12 unlisted offsets
    wr_reg(1'b0, 4'hE, 16'hFFFF);
    wr_reg(1'b1, 4'hE, 16'hFFFF);
    rd_reg(1'b0, 4'h8, 16'h1237, rd); chk("R12 value untouched", rd, 16'h0A08);
    rd_reg(1'b0, 4'h4, 16'h1237, rd); chk("R12 clear offset reads 0", rd, 16'h0000);
    rd_reg(1'b1, 4'h0, 16'h1237, rd); chk("R12 ack offset reads 0", rd, 16'h0000);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] pins, wd;
      logic        w, win;
      logic [3:0]  a;
      pins = (($urandom % 4) == 0) ? 16'($urandom) : cur_pins;
      w    = ($urandom % 2) == 1;
      win  = ($urandom % 3) != 0;
      a    = {3'($urandom % 8), 1'b0};
      wd   = 16'($urandom);
      if (w && win && a == 4'hA && ($urandom % 2) == 1) wd = 16'($urandom) & 16'h00FF;
      step(w, win, a, wd, pins, rd);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule